// File: doc/BRIEF.md
# Shared GPIO and Serial Port Mux

This block controls a small group of bidirectional pads. In its default mode, every pad is a general-purpose pin. Each pin has its own direction bit and output latch bit, and software reads the pins through a read-only view. A single serial-enable bit gives three of the pads to a synchronous serial engine that sits outside the block. The serial-clock pad drives only when a master flag is set. The data-out pad always drives. The data-in pad never drives. The remaining pad stays general-purpose.

A backup input switches every pad to high impedance and turns off every input buffer, whatever the registers hold. The registers keep their contents through backup, so the previous pin configuration takes effect again on the first cycle after backup is released. Software uses a two-bit register interface: address 0 is the output latch, 1 is the direction register, 2 is the control register, and 3 is the pin view.

Top module: `shared_port_mux`

## Requirements
- R1: After reset, the latch, direction and control registers read 0, every pad has its output enable at 0 and its input buffer enable at 1, and every pin is a general-purpose input.
- R2: When serial mode is off and backup is low, pad i drives exactly when direction bit i is 1 (0 = input, 1 = output), and a driving pad carries latch bit i.
- R3: A write to address 0 (latch), 1 (direction) or 2 (control: bit 0 serial enable, bit 1 serial master) is read back from the same address on the next cycle. A write to address 3 changes no register.
- R4: When serial mode is on and backup is low, pad 2 drives the serial data-out input and pad 3 does not drive, whatever the direction register holds.
- R5: When serial mode is on and backup is low, pad 1 drives the serial clock input if the master bit is 1. If the master bit is 0, pad 1 does not drive and forwards pad input 1 to the serial clock output. Outside this case, the serial clock output is 0.
- R6: In serial mode, pad 0 keeps its general-purpose behaviour under direction bit 0 and latch bit 0.
- R7: While backup is high, every pad has its output enable at 0 and its input buffer enable at 0.
- R8: While backup is high, reading address 3 returns 0.
- R9: Outside backup, bit i of the address 3 read returns latch bit i if pad i is driving. Otherwise it returns the pad input value captured at the previous clock edge.
- R10: The latch, direction and control registers keep their values through backup, accept writes during backup, and control the pads again as soon as backup falls.
- R11: The serial data output equals pad input 3 when serial mode is on and backup is low, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | NUM_PINS | Write data |
| reg_rdata | output | NUM_PINS | Read data for reg_addr |
| backup_mode | input | 1 | Forces all pads off and high impedance |
| pad_in | input | NUM_PINS | Pad input values |
| pad_out | output | NUM_PINS | Pad output values |
| pad_oe | output | NUM_PINS | Pad output enables |
| pad_ie | output | NUM_PINS | Pad input buffer enables |
| ser_sck_drive | input | 1 | Serial clock from the engine (master) |
| ser_sdo_drive | input | 1 | Serial data out from the engine |
| ser_sck_in | output | 1 | Serial clock from the pad (slave) |
| ser_sdi | output | 1 | Serial data in from the pad |

## Verification
A wrong register bit in the direction, latch or control state shows at the pad output enables or values in the same cycle. It also shows at the read port on the next access to that register. A stale or missing capture of the pad inputs appears in the address 3 read one cycle after the pad value changes. A register that is cleared or corrupted during backup shows as wrong enables on the first cycle after backup falls. The reference model compares every pad, the read data and both serial outputs on every cycle, so any such fault is reported within one clock of the moment it becomes visible.

// File: rtl/spmux_pkg.sv
package spmux_pkg;

    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        ADDR_LATCH = 2'd0,
        ADDR_DIR   = 2'd1,
        ADDR_CTRL  = 2'd2,
        ADDR_PINS  = 2'd3
    } reg_addr_e;

    typedef enum logic [1:0] {
        ROLE_GPIO,
        ROLE_SCK,
        ROLE_SDO,
        ROLE_SDI
    } pin_role_e;

    localparam int CTRL_SER_BIT = 0;
    localparam int CTRL_MST_BIT = 1;

    typedef struct packed {
        logic master;
        logic ser_en;
    } ctrl_t;

endpackage

// File: rtl/spmux_regs.sv
module spmux_regs
    import spmux_pkg::*;
#(
    parameter int NUM_PINS = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [NUM_PINS-1:0] wdata,
    input  logic [NUM_PINS-1:0] pin_view,
    output logic [NUM_PINS-1:0] latch_q,
    output logic [NUM_PINS-1:0] dir_q,
    output ctrl_t               ctrl_q,
    output logic [NUM_PINS-1:0] rdata
);

    typedef struct packed {
        logic [NUM_PINS-1:0] latch;
        logic [NUM_PINS-1:0] dir;
        ctrl_t               ctrl;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) begin
            case (reg_addr_e'(addr))
                ADDR_LATCH: st_d.latch = wdata;
                ADDR_DIR:   st_d.dir   = wdata;
                ADDR_CTRL: begin
                    st_d.ctrl.ser_en = wdata[CTRL_SER_BIT];
                    st_d.ctrl.master = wdata[CTRL_MST_BIT];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign latch_q = st_q.latch;
    assign dir_q   = st_q.dir;
    assign ctrl_q  = st_q.ctrl;

    always_comb begin
        rdata = '0;
        case (reg_addr_e'(addr))
            ADDR_LATCH: rdata = st_q.latch;
            ADDR_DIR:   rdata = st_q.dir;
            ADDR_CTRL: begin
                rdata[CTRL_SER_BIT] = st_q.ctrl.ser_en;
                rdata[CTRL_MST_BIT] = st_q.ctrl.master;
            end
            default:    rdata = pin_view;
        endcase
    end

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(st_q));

    p_pins_readonly_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == ADDR_PINS) |=> $stable(st_q));

    p_dir_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == ADDR_DIR) |=> dir_q == $past(wdata));

endmodule

// File: rtl/spmux_pin.sv
module spmux_pin (
    input  logic clk,
    input  logic rst_n,
    input  logic backup,
    input  logic gp_dir,
    input  logic gp_val,
    input  logic ser_claim,
    input  logic ser_oe,
    input  logic ser_val,
    output logic oe,
    output logic out,
    output logic ie
);

    typedef struct packed {
        logic drive;
        logic val;
    } pin_sel_t;

    pin_sel_t sel;

    always_comb begin
        if (ser_claim) begin
            sel.drive = ser_oe;
            sel.val   = ser_val;
        end else begin
            sel.drive = gp_dir;
            sel.val   = gp_val;
        end
        oe  = sel.drive & ~backup;
        out = oe & sel.val;
        ie  = ~backup;
    end

    p_backup_hiz_r7: assert property (@(posedge clk) disable iff (!rst_n)
        backup |-> (!oe && !ie));

    p_gp_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!backup && !ser_claim) |-> (oe == gp_dir && (!oe || out == gp_val)));

endmodule

// File: rtl/spmux_in_sample.sv
module spmux_in_sample #(
    parameter int NUM_PINS = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pad_in,
    input  logic [NUM_PINS-1:0] ie,
    input  logic [NUM_PINS-1:0] oe,
    input  logic [NUM_PINS-1:0] latch,
    output logic [NUM_PINS-1:0] view
);

    logic [NUM_PINS-1:0] samp_d, samp_q;

    always_comb begin
        samp_d = pad_in & ie;
        view   = ie & ((oe & latch) | (~oe & samp_q));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) samp_q <= '0;
        else        samp_q <= samp_d;
    end

    p_sampled_input_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ie == '1 && oe == '0) ##1 (ie == '1 && oe == '0) |-> view == $past(pad_in));

    p_output_reads_latch_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ie == '1 && oe == '1) |-> view == latch);

endmodule

// File: rtl/shared_port_mux.sv
module shared_port_mux
    import spmux_pkg::*;
#(
    parameter int NUM_PINS = 4,
    parameter int SCK_PIN  = 1,
    parameter int SDO_PIN  = 2,
    parameter int SDI_PIN  = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_we,
    input  logic [1:0]          reg_addr,
    input  logic [NUM_PINS-1:0] reg_wdata,
    output logic [NUM_PINS-1:0] reg_rdata,
    input  logic                backup_mode,
    input  logic [NUM_PINS-1:0] pad_in,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pad_oe,
    output logic [NUM_PINS-1:0] pad_ie,
    input  logic                ser_sck_drive,
    input  logic                ser_sdo_drive,
    output logic                ser_sck_in,
    output logic                ser_sdi
);

    logic [NUM_PINS-1:0] latch_q;
    logic [NUM_PINS-1:0] dir_q;
    ctrl_t               ctrl_q;
    logic [NUM_PINS-1:0] pin_view;
    logic                ser_live;

    assign ser_live = ctrl_q.ser_en & ~backup_mode;

    spmux_regs #(.NUM_PINS(NUM_PINS)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (reg_we),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .pin_view (pin_view),
        .latch_q  (latch_q),
        .dir_q    (dir_q),
        .ctrl_q   (ctrl_q),
        .rdata    (reg_rdata)
    );

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        localparam pin_role_e ROLE = (i == SCK_PIN) ? ROLE_SCK :
                                     (i == SDO_PIN) ? ROLE_SDO :
                                     (i == SDI_PIN) ? ROLE_SDI : ROLE_GPIO;
        logic claim, s_oe, s_val;

        if (ROLE == ROLE_SCK) begin : g_sck
            assign claim = ctrl_q.ser_en;
            assign s_oe  = ctrl_q.master;
            assign s_val = ser_sck_drive;
        end else if (ROLE == ROLE_SDO) begin : g_sdo
            assign claim = ctrl_q.ser_en;
            assign s_oe  = 1'b1;
            assign s_val = ser_sdo_drive;
        end else if (ROLE == ROLE_SDI) begin : g_sdi
            assign claim = ctrl_q.ser_en;
            assign s_oe  = 1'b0;
            assign s_val = 1'b0;
        end else begin : g_gpio
            assign claim = 1'b0;
            assign s_oe  = 1'b0;
            assign s_val = 1'b0;
        end

        spmux_pin u_pin (
            .clk       (clk),
            .rst_n     (rst_n),
            .backup    (backup_mode),
            .gp_dir    (dir_q[i]),
            .gp_val    (latch_q[i]),
            .ser_claim (claim),
            .ser_oe    (s_oe),
            .ser_val   (s_val),
            .oe        (pad_oe[i]),
            .out       (pad_out[i]),
            .ie        (pad_ie[i])
        );
    end

    spmux_in_sample #(.NUM_PINS(NUM_PINS)) u_in (
        .clk    (clk),
        .rst_n  (rst_n),
        .pad_in (pad_in),
        .ie     (pad_ie),
        .oe     (pad_oe),
        .latch  (latch_q),
        .view   (pin_view)
    );

    assign ser_sck_in = ser_live & ~ctrl_q.master & pad_in[SCK_PIN];
    assign ser_sdi    = ser_live & pad_in[SDI_PIN];

    p_sdo_sdi_roles_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.ser_en && !backup_mode) |->
            (pad_oe[SDO_PIN] && !pad_oe[SDI_PIN] && pad_out[SDO_PIN] == ser_sdo_drive));

    p_sck_master_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.ser_en && !backup_mode) |-> (pad_oe[SCK_PIN] == ctrl_q.master));

    p_sdi_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q.ser_en || backup_mode) |-> !ser_sdi);

    p_backup_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (backup_mode && reg_addr == 2'd3) |-> reg_rdata == '0);

endmodule

// File: tb/tb_shared_port_mux.sv
module tb_shared_port_mux;

    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         reg_we = 1'b0;
    logic [1:0]   reg_addr = '0;
    logic [N-1:0] reg_wdata = '0;
    logic [N-1:0] reg_rdata;
    logic         backup_mode = 1'b0;
    logic [N-1:0] pad_in = '0;
    logic [N-1:0] pad_out, pad_oe, pad_ie;
    logic         ser_sck_drive = 1'b0, ser_sdo_drive = 1'b0;
    logic         ser_sck_in, ser_sdi;

    int tests = 0;
    int fails = 0;
    bit done = 0;
    string phase = "R1";

    always #10 clk = ~clk;

    shared_port_mux dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .backup_mode(backup_mode),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_ie(pad_ie),
        .ser_sck_drive(ser_sck_drive), .ser_sdo_drive(ser_sdo_drive),
        .ser_sck_in(ser_sck_in), .ser_sdi(ser_sdi)
    );

    // Behavioural reference state
    bit [N-1:0] m_latch, m_dir, m_samp;
    bit m_ser, m_mst;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_latch = '0; m_dir = '0; m_samp = '0; m_ser = 0; m_mst = 0;
        end else begin
            m_samp = backup_mode ? '0 : pad_in;
            if (reg_we) begin
                if (reg_addr == 0) m_latch = reg_wdata;
                else if (reg_addr == 1) m_dir = reg_wdata;
                else if (reg_addr == 2) begin m_ser = reg_wdata[0]; m_mst = reg_wdata[1]; end
            end
        end
    end

    task automatic chk(string req, string what, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s (%s) %s: actual %0h expected %0h", req, phase, what, act, exp);
        end
    endtask

    task automatic check_all();
        bit [N-1:0] e_oe, e_out, e_view;
        bit [N-1:0] e_rd;
        for (int i = 0; i < N; i++) begin
            bit drv, val;
            string tag;
            if (m_ser && i == 1)      begin drv = m_mst; val = ser_sck_drive; tag = "R5"; end
            else if (m_ser && i == 2) begin drv = 1;     val = ser_sdo_drive; tag = "R4"; end
            else if (m_ser && i == 3) begin drv = 0;     val = 0;             tag = "R4"; end
            else begin drv = m_dir[i]; val = m_latch[i]; tag = m_ser ? "R6" : "R2"; end
            if (backup_mode) begin drv = 0; tag = "R7"; end
            e_oe[i]   = drv;
            e_out[i]  = drv & val;
            e_view[i] = backup_mode ? 1'b0 : (drv ? m_latch[i] : m_samp[i]);
            chk(tag, $sformatf("pad_oe[%0d]", i), int'(pad_oe[i]), int'(drv));
            if (drv) chk(tag, $sformatf("pad_out[%0d]", i), int'(pad_out[i]), int'(val));
        end
        chk("R7", "pad_ie", int'(pad_ie), backup_mode ? 0 : int'({N{1'b1}}));
        case (reg_addr)
            2'd0: e_rd = m_latch;
            2'd1: e_rd = m_dir;
            2'd2: e_rd = {{(N-2){1'b0}}, m_mst, m_ser};
            default: e_rd = e_view;
        endcase
        chk(reg_addr == 3 ? (backup_mode ? "R8" : "R9") : "R3", $sformatf("rdata@%0d", reg_addr),
            int'(reg_rdata), int'(e_rd));
        chk("R5", "ser_sck_in", int'(ser_sck_in),
            int'(m_ser && !backup_mode && !m_mst && pad_in[1]));
        chk("R11", "ser_sdi", int'(ser_sdi), int'(m_ser && !backup_mode && pad_in[3]));
    endtask

    bit [7:0] lfsr = 8'h5a;

    task automatic tick(bit we, bit [1:0] addr, bit [N-1:0] wd);
        @(negedge clk);
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        reg_we = we; reg_addr = addr; reg_wdata = wd;
        pad_in = lfsr[N-1:0];
        ser_sck_drive = lfsr[5];
        ser_sdo_drive = lfsr[6];
        #1;
        check_all();
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) tick(0, 2'(k % 4), '0);
    endtask

    initial begin
        #1;
        // R1: reset state
        chk("R1", "pad_oe", int'(pad_oe), 0);
        chk("R1", "pad_ie", int'(pad_ie), 'hf);
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        idle(4);

        phase = "R2";
        tick(1, 0, 4'b0110);
        tick(1, 1, 4'b1010);
        idle(12);
        tick(1, 1, 4'b0101);
        idle(8);

        phase = "R3";
        tick(1, 3, 4'b1111);
        idle(4);
        tick(1, 2, 4'b0000);
        idle(4);

        phase = "R4";
        tick(1, 1, 4'b0000);
        tick(1, 2, 4'b0001);
        idle(10);
        tick(1, 1, 4'b1111);
        idle(8);
        phase = "R6";
        tick(1, 1, 4'b0010);
        tick(1, 0, 4'b1001);
        idle(6);

        phase = "R5";
        tick(1, 2, 4'b0011);
        idle(10);

        phase = "R10";
        @(negedge clk) backup_mode = 1'b1;
        idle(8);
        tick(1, 0, 4'b0011);
        idle(4);
        @(negedge clk) backup_mode = 1'b0;
        idle(8);
        tick(1, 2, 4'b0000);
        idle(6);
        @(negedge clk) backup_mode = 1'b1;
        tick(1, 1, 4'b1100);
        idle(4);
        @(negedge clk) backup_mode = 1'b0;
        idle(8);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule